// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block turns one flash-controller instruction at a time into the timed address cycles of an 8-bit NAND flash bus. An instruction is one of four kinds: a timed pause, a column address, a page address, or a byte taken from a four-byte user register. The block forms the address value from its configuration inputs and drives it one byte at a time on the data bus. For every byte it raises the address latch enable and pulses the active-low write enable. Command bytes, data transfer, error correction and chip selects are handled elsewhere. The command latch output is held low here.

Each byte takes one setup cycle, then a programmable number of cycles with write enable low, then a programmable number with it high. A one-cycle done pulse marks the end of each instruction. The block keeps a write pointer into the user register, and a sequence-start input clears that pointer. The configuration and timing inputs are captured on the cycle an instruction is accepted.

Top module: `nand_addr_seq`

## Requirements
- R1: Every address byte is driven on `bus_data` with `ale` high for its whole cycle. `we_n` is never low while `ale` is low, and `bus_data` does not change while `we_n` is low. The byte value is the one on `bus_data` when `we_n` rises.
- R2: A no-op (`instr_op` = 0) takes the time of one byte cycle. During it `we_n` stays high and `ale` and `cle` stay low.
- R3: A column address (`instr_op` = 1) is one byte when `page_wide` = 0 and two bytes when `page_wide` = 1.
- R4: The column value is `col_idx`, except that when `byte_count` = 0 every column byte is 0x00.
- R5: A page address (`instr_op` = 2) is 2 bytes when `addr_len` = 0, 3 bytes when it is 1, and 4 bytes when it is 2 or 3.
- R6: The page value is `{blk_idx, pg_idx}`, with `blk_idx` above `pg_idx`. Every multi-byte address is sent least significant byte first: byte k is bits 8k+7:8k.
- R7: A user address (`instr_op` = 3) sends byte p of `user_reg` (bits 8p+7:8p), where p is `wr_ptr`. The pointer then advances by one.
- R8: Once `wr_ptr` has reached 4, every further user address sends 0x00, and `wr_ptr` stays at 4.
- R9: A `seq_start` pulse clears `wr_ptr` to 0.
- R10: A byte takes 1 + L + H cycles, where L and H are `we_lo_cnt` and `we_hi_cnt`, and a count of 0 acts as 1. For an n-byte instruction accepted on clock edge E, `done` is high for exactly the one cycle that follows edge E + n·(1+L+H). `busy` is high from acceptance until `done`. An `instr_valid` seen while `busy` is high is ignored.
- R11: After reset, `we_n` = 1, and `ale`, `cle`, `done`, `busy`, `bus_data` and `wr_ptr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_start | input | 1 | Start of a new instruction sequence; clears the user pointer |
| instr_valid | input | 1 | Instruction present; accepted when not busy |
| instr_op | input | 2 | 0 no-op, 1 column, 2 page, 3 user address |
| page_wide | input | 1 | Column is two bytes when set |
| addr_len | input | 2 | Page address length select |
| byte_count | input | BCW | Transfer byte count; zero forces a zero column |
| col_idx | input | COLW | Column index |
| blk_idx | input | BLKW | Block index |
| pg_idx | input | PGW | Page-in-block index |
| user_reg | input | 8·NUSR | User address bytes |
| we_lo_cnt | input | TW | Write-enable low time in clocks |
| we_hi_cnt | input | TW | Write-enable high time in clocks |
| bus_data | output | 8 | Flash data bus byte |
| ale | output | 1 | Address latch enable |
| cle | output | 1 | Command latch enable (held low) |
| we_n | output | 1 | Active-low write enable |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle end-of-instruction pulse |
| wr_ptr | output | PTRW | User register write pointer |

## Verification
A fault in the phase counter or the byte counter shows up in the same instruction. `done` then arrives on the wrong cycle, or the number of `we_n` rising edges differs from the expected byte count. A corrupted shift register or a wrong byte selection appears on `bus_data` at the very next `we_n` rising edge. A user pointer that is stuck, skips, or fails to saturate shows up on `wr_ptr` right after the next accepted user instruction, and in the byte that instruction sends.

// File: rtl/nas_pkg.sv
package nas_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_COL  = 2'd1,
    OP_PAGE = 2'd2,
    OP_USER = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LOW,
    PH_HIGH
  } ph_e;
endpackage

// File: rtl/nas_addr_gen.sv
module nas_addr_gen
  import nas_pkg::*;
#(
  parameter int BCW  = 12,
  parameter int COLW = 16,
  parameter int BLKW = 26,
  parameter int PGW  = 6
) (
  input  op_e             op,
  input  logic            page_wide,
  input  logic [1:0]      addr_len,
  input  logic [BCW-1:0]  byte_count,
  input  logic [COLW-1:0] col_idx,
  input  logic [BLKW-1:0] blk_idx,
  input  logic [PGW-1:0]  pg_idx,
  input  logic [7:0]      user_byte,
  output logic [31:0]     addr_word,
  output logic [2:0]      nbytes,
  output logic            strobe_en
);
  localparam int PAW = BLKW + PGW;

  logic [PAW-1:0] page_val;
  assign page_val = {blk_idx, pg_idx};

  always_comb begin
    addr_word = 32'h0;
    nbytes    = 3'd1;
    strobe_en = 1'b1;
    unique case (op)
      OP_NOP: begin
        strobe_en = 1'b0;
      end
      OP_COL: begin
        addr_word = (byte_count == '0) ? 32'h0 : 32'(col_idx);
        nbytes    = page_wide ? 3'd2 : 3'd1;
      end
      OP_PAGE: begin
        addr_word = 32'(page_val);
        case (addr_len)
          2'd0:    nbytes = 3'd2;
          2'd1:    nbytes = 3'd3;
          default: nbytes = 3'd4;
        endcase
      end
      OP_USER: begin
        addr_word = 32'(user_byte);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nas_user_ptr.sv
module nas_user_ptr #(
  parameter int NUSR = 4,
  parameter int PTRW = $clog2(NUSR + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seq_start,
  input  logic              step,
  input  logic [8*NUSR-1:0] user_reg,
  output logic [7:0]        user_byte,
  output logic [PTRW-1:0]   wr_ptr
);
  localparam logic [PTRW-1:0] FULL = PTRW'(NUSR);

  logic [PTRW-1:0] ptr_q, ptr_eff;

  assign ptr_eff = seq_start ? '0 : ptr_q;
  assign wr_ptr  = ptr_q;

  always_comb begin
    user_byte = 8'h00;
    for (int i = 0; i < NUSR; i++) begin
      if (ptr_eff == PTRW'(i)) user_byte = user_reg[i*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (step && (ptr_eff < FULL)) begin
      ptr_q <= ptr_eff + 1'b1;
    end else begin
      ptr_q <= ptr_eff;
    end
  end

  // R7: an accepted user step below the cap moves the pointer up by one
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (step && !seq_start && (ptr_q < FULL)) |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R8: the pointer never passes the last user byte
  assert_ptr_cap_R8: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= FULL);

  // R9: a sequence start without a step leaves the pointer at zero
  assert_ptr_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (seq_start && !step) |=> (ptr_q == '0));
endmodule

// File: rtl/nas_wr_timer.sv
module nas_wr_timer
  import nas_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          strobe_en,
  input  logic [2:0]    nbytes,
  input  logic [31:0]   addr_word,
  input  logic [TW-1:0] lo_cnt,
  input  logic [TW-1:0] hi_cnt,
  output logic          busy,
  output logic [7:0]    bus_data,
  output logic          ale,
  output logic          we_n,
  output logic          done
);
  ph_e           ph;
  logic [TW-1:0] tcnt, lo_q, hi_q;
  logic [2:0]    left;
  logic [31:0]   shift;
  logic          stb;

  function automatic logic [TW-1:0] clamp1(input logic [TW-1:0] x);
    return (x == '0) ? TW'(1) : x;
  endfunction

  assign busy = (ph != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      tcnt     <= '0;
      lo_q     <= TW'(1);
      hi_q     <= TW'(1);
      left     <= '0;
      shift    <= '0;
      stb      <= 1'b0;
      bus_data <= 8'h00;
      ale      <= 1'b0;
      we_n     <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (accept) begin
            ph       <= PH_SETUP;
            shift    <= addr_word;
            left     <= nbytes;
            stb      <= strobe_en;
            lo_q     <= clamp1(lo_cnt);
            hi_q     <= clamp1(hi_cnt);
            bus_data <= strobe_en ? addr_word[7:0] : 8'h00;
            ale      <= strobe_en;
            we_n     <= 1'b1;
          end
        end
        PH_SETUP: begin
          ph   <= PH_LOW;
          tcnt <= lo_q - 1'b1;
          we_n <= ~stb;
        end
        PH_LOW: begin
          if (tcnt == '0) begin
            ph   <= PH_HIGH;
            tcnt <= hi_q - 1'b1;
            we_n <= 1'b1;
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        PH_HIGH: begin
          if (tcnt != '0) begin
            tcnt <= tcnt - 1'b1;
          end else if (left > 3'd1) begin
            ph       <= PH_SETUP;
            left     <= left - 1'b1;
            shift    <= shift >> 8;
            bus_data <= stb ? shift[15:8] : 8'h00;
          end else begin
            ph       <= PH_IDLE;
            ale      <= 1'b0;
            bus_data <= 8'h00;
            done     <= 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R1: write enable only falls inside an address cycle
  assert_ale_with_we_R1: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> ale);

  // R1: the byte holds while write enable is low
  assert_data_stable_R1: assert property (@(posedge clk) disable iff (rst)
    (!we_n && !$past(we_n)) |-> $stable(bus_data));

  // R2: a pause instruction raises no strobe
  assert_nop_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !stb) |-> (we_n && !ale));

  // R10: done lasts one cycle and is never raised while busy
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import nas_pkg::*;
#(
  parameter int BCW  = 12,
  parameter int COLW = 16,
  parameter int BLKW = 26,
  parameter int PGW  = 6,
  parameter int NUSR = 4,
  parameter int TW   = 4,
  localparam int PTRW = $clog2(NUSR + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seq_start,
  input  logic              instr_valid,
  input  logic [1:0]        instr_op,
  input  logic              page_wide,
  input  logic [1:0]        addr_len,
  input  logic [BCW-1:0]    byte_count,
  input  logic [COLW-1:0]   col_idx,
  input  logic [BLKW-1:0]   blk_idx,
  input  logic [PGW-1:0]    pg_idx,
  input  logic [8*NUSR-1:0] user_reg,
  input  logic [TW-1:0]     we_lo_cnt,
  input  logic [TW-1:0]     we_hi_cnt,
  output logic [7:0]        bus_data,
  output logic              ale,
  output logic              cle,
  output logic              we_n,
  output logic              busy,
  output logic              done,
  output logic [PTRW-1:0]   wr_ptr
);
  op_e         op;
  logic        accept, step, strobe_en;
  logic [7:0]  user_byte;
  logic [31:0] addr_word;
  logic [2:0]  nbytes;

  assign op     = op_e'(instr_op);
  assign accept = instr_valid && !busy;
  assign step   = accept && (op == OP_USER);
  assign cle    = 1'b0;

  nas_user_ptr #(.NUSR(NUSR), .PTRW(PTRW)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .seq_start (seq_start),
    .step      (step),
    .user_reg  (user_reg),
    .user_byte (user_byte),
    .wr_ptr    (wr_ptr)
  );

  nas_addr_gen #(.BCW(BCW), .COLW(COLW), .BLKW(BLKW), .PGW(PGW)) u_gen (
    .op         (op),
    .page_wide  (page_wide),
    .addr_len   (addr_len),
    .byte_count (byte_count),
    .col_idx    (col_idx),
    .blk_idx    (blk_idx),
    .pg_idx     (pg_idx),
    .user_byte  (user_byte),
    .addr_word  (addr_word),
    .nbytes     (nbytes),
    .strobe_en  (strobe_en)
  );

  nas_wr_timer #(.TW(TW)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .strobe_en (strobe_en),
    .nbytes    (nbytes),
    .addr_word (addr_word),
    .lo_cnt    (we_lo_cnt),
    .hi_cnt    (we_hi_cnt),
    .busy      (busy),
    .bus_data  (bus_data),
    .ale       (ale),
    .we_n      (we_n),
    .done      (done)
  );

  // R4: a column accepted with a zero byte count starts with a zero byte
  assert_col_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && (op == OP_COL) && (byte_count == '0)) |=> (bus_data == 8'h00));

  // R10: an accepted instruction makes the block busy on the next cycle
  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);
endmodule

// File: tb/test_nand_addr_seq.sv
module test_nand_addr_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seq_start = 1'b0;
  logic        instr_valid = 1'b0;
  logic [1:0]  instr_op = 2'd0;
  logic        page_wide = 1'b0;
  logic [1:0]  addr_len = 2'd0;
  logic [11:0] byte_count = 12'd0;
  logic [15:0] col_idx = 16'd0;
  logic [25:0] blk_idx = 26'd0;
  logic [5:0]  pg_idx = 6'd0;
  logic [31:0] user_reg = 32'hDDCC_BBAA;
  logic [3:0]  we_lo_cnt = 4'd1;
  logic [3:0]  we_hi_cnt = 4'd1;
  logic [7:0]  bus_data;
  logic        ale, cle, we_n, busy, done;
  logic [2:0]  wr_ptr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  nand_addr_seq i_nand_addr_seq (
    .clk(clk), .rst(rst), .seq_start(seq_start), .instr_valid(instr_valid),
    .instr_op(instr_op), .page_wide(page_wide), .addr_len(addr_len),
    .byte_count(byte_count), .col_idx(col_idx), .blk_idx(blk_idx),
    .pg_idx(pg_idx), .user_reg(user_reg), .we_lo_cnt(we_lo_cnt),
    .we_hi_cnt(we_hi_cnt), .bus_data(bus_data), .ale(ale), .cle(cle),
    .we_n(we_n), .busy(busy), .done(done), .wr_ptr(wr_ptr)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        pw;
    logic [1:0]  al;
    logic [11:0] bc;
    logic [15:0] col;
    logic [25:0] blk;
    logic [5:0]  pg;
    logic [3:0]  lo;
    logic [3:0]  hi;
    logic [2:0]  n;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b0, 2'd0, 12'd5, 16'hA53C, 26'd0, 6'd0, 4'd1, 4'd1, 3'd1, 32'h0000_003C},
    '{2'd1, 1'b1, 2'd0, 12'd5, 16'hA53C, 26'd0, 6'd0, 4'd2, 4'd3, 3'd2, 32'h0000_A53C},
    '{2'd1, 1'b1, 2'd0, 12'd0, 16'hA53C, 26'd0, 6'd0, 4'd1, 4'd2, 3'd2, 32'h0000_0000},
    '{2'd2, 1'b0, 2'd0, 12'd9, 16'h0, 26'h0123456, 6'h15, 4'd3, 4'd1, 3'd2, 32'h048D_1595},
    '{2'd2, 1'b0, 2'd1, 12'd9, 16'h0, 26'h0123456, 6'h15, 4'd1, 4'd2, 3'd3, 32'h048D_1595},
    '{2'd2, 1'b1, 2'd2, 12'd9, 16'h0, 26'h3FFFFFF, 6'h00, 4'd1, 4'd1, 3'd4, 32'hFFFF_FFC0},
    '{2'd2, 1'b0, 2'd3, 12'd9, 16'h0, 26'h0000001, 6'h3F, 4'd0, 4'd0, 3'd4, 32'h0000_007F},
    '{2'd0, 1'b0, 2'd0, 12'd0, 16'h0, 26'd0, 6'd0, 4'd4, 4'd5, 3'd0, 32'h0000_0000},
    '{2'd1, 1'b0, 2'd0, 12'd1, 16'h00FF, 26'd0, 6'd0, 4'd15, 4'd15, 3'd1, 32'h0000_00FF}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  // Issue one instruction and observe it to the done pulse.
  task automatic run_instr(input vec_t v, input string req, input bit poke_busy);
    int n_got = 0;
    int cnt = 0;
    int period;
    int exp_done;
    int done_at = -1;
    bit prev_we = 1'b1;
    bit strobe_bad = 1'b0;
    bit byte_bad = 1'b0;
    logic [7:0] bad_act = 8'h0;
    logic [7:0] bad_exp = 8'h0;
    period   = 1 + ((v.lo == 0) ? 1 : int'(v.lo)) + ((v.hi == 0) ? 1 : int'(v.hi));
    exp_done = ((v.op == 2'd0) ? 1 : int'(v.n)) * period + 1;
    @(negedge clk);
    instr_op = v.op; page_wide = v.pw; addr_len = v.al; byte_count = v.bc;
    col_idx = v.col; blk_idx = v.blk; pg_idx = v.pg;
    we_lo_cnt = v.lo; we_hi_cnt = v.hi;
    instr_valid = 1'b1;
    while (done_at < 0 && cnt < 2000) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) instr_valid = 1'b0;
      if (poke_busy && cnt == 3) begin
        instr_op = 2'd3;
        instr_valid = 1'b1;
      end
      if (poke_busy && cnt == 4) instr_valid = 1'b0;
      if (!we_n && !ale) strobe_bad = 1'b1;
      if (v.op == 2'd0 && (ale || !we_n || cle)) strobe_bad = 1'b1;
      if (!prev_we && we_n) begin
        if (n_got < 4 && bus_data !== v.exp[n_got*8 +: 8] && !byte_bad) begin
          byte_bad = 1'b1;
          bad_act = bus_data;
          bad_exp = v.exp[n_got*8 +: 8];
        end
        n_got++;
      end
      prev_we = we_n;
      if (done) done_at = cnt;
    end
    check(!strobe_bad, (v.op == 2'd0) ? "R2" : "R1", {req, " strobes"}, strobe_bad, 0);
    check(n_got == int'(v.n), req, "byte count", n_got, v.n);
    check(!byte_bad, req, "byte value", bad_act, bad_exp);
    check(done_at == exp_done, "R10", {req, " done cycle"}, done_at, exp_done);
    @(negedge clk);
    check(!done && !busy, "R10", {req, " done one cycle"}, done, 0);
  endtask

  initial begin
    vec_t u;
    repeat (3) @(negedge clk);
    // R11: reset values
    check(we_n === 1'b1 && ale === 1'b0 && cle === 1'b0, "R11", "strobes", {we_n, ale, cle}, 3'b100);
    check(done === 1'b0 && busy === 1'b0, "R11", "done/busy", {done, busy}, 0);
    check(bus_data === 8'h00 && wr_ptr === 3'd0, "R11", "data/ptr", {bus_data, wr_ptr}, 0);
    rst = 1'b0;
    @(negedge clk);

    // Table: R3 R4 R5 R6 R2 R10 vectors
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0:    run_instr(VECS[i], "R2", 1'b0);
        2'd1:    run_instr(VECS[i], (VECS[i].bc == 0) ? "R4" : "R3", 1'b0);
        default: run_instr(VECS[i], (VECS[i].al == 0) ? "R5" : "R6", 1'b0);
      endcase
    end

    // R7 R8: user bytes walk the register, then run out to zero
    @(negedge clk);
    seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
    check(wr_ptr == 3'd0, "R9", "ptr after start", wr_ptr, 0);
    for (int k = 0; k < 6; k++) begin
      u = '0;
      u.op = 2'd3; u.lo = 4'd2; u.hi = 4'd1; u.n = 3'd1;
      u.exp = (k < 4) ? 32'(user_reg[k*8 +: 8]) : 32'h0;
      run_instr(u, (k < 4) ? "R7" : "R8", 1'b0);
      check(wr_ptr == 3'((k < 4) ? k + 1 : 4), (k < 4) ? "R7" : "R8", "ptr", wr_ptr, (k < 4) ? k + 1 : 4);
    end

    // R9: restart clears the pointer and the first byte is sent again
    @(negedge clk);
    seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
    check(wr_ptr == 3'd0, "R9", "ptr cleared", wr_ptr, 0);
    u = '0;
    u.op = 2'd3; u.lo = 4'd1; u.hi = 4'd1; u.n = 3'd1; u.exp = 32'h0000_00AA;
    run_instr(u, "R9", 1'b0);
    check(wr_ptr == 3'd1, "R9", "ptr after first", wr_ptr, 1);

    // R10: an instruction offered while busy is ignored
    u = '0;
    u.op = 2'd1; u.pw = 1'b1; u.bc = 12'd4; u.col = 16'h1234;
    u.lo = 4'd3; u.hi = 4'd3; u.n = 3'd2; u.exp = 32'h0000_1234;
    run_instr(u, "R10", 1'b1);
    repeat (3) @(negedge clk);
    check(wr_ptr == 3'd1 && !busy && we_n && !ale, "R10", "busy offer ignored",
          {wr_ptr, busy}, {3'd1, 1'b0});

    finish_run();
  end
endmodule